// File: doc/BRIEF.md
# Multiplexed Display Refresh Controller

This block drives a time-multiplexed character display. It keeps a small character store and steps a position counter across the digit positions at a rate set by a clock prescaler. For each position it presents the stored character on two 4-bit output nibbles, together with a scan code that selects the matching digit. The scan code is either a 4-bit binary position or a one-hot pattern over four lines.

A host writes characters through a simple strobe-and-data port. Successive writes fill the store from position 0 upward, and the write pointer wraps back to 0 after the last position. Each nibble can be blanked on its own. A blanked nibble drives its half of a loadable blank code in place of the stored data. A display-blank output is high around every digit switch, so the digit drivers are dark while the scan code changes. The host can also force this output high.

Top module: `digit_refresh_ctrl`

## Requirements
- R1: After reset, every stored character, the write pointer, the blank code and the scan position are all 0. The first cycle out of reset shows scan code 0, `out_a` = 0, `out_b` = 0 and `disp_blank` = 1.
- R2: When `wr_en` is high and `code_wr` is low at a clock edge, `wr_data` is stored at the write pointer and the pointer advances by one. The pointer starts at 0 and wraps from 15 back to 0, so the 17th write overwrites position 0.
- R3: When neither nibble is blanked, `out_a` carries bits [7:4] and `out_b` carries bits [3:0] of the character at the current scan position. They change in the same cycle as the scan code.
- R4: While `blank_a` is high, `out_a` shows blank-code bits [7:4] and `out_b` is unaffected. While `blank_b` is high, `out_b` shows blank-code bits [3:0] and `out_a` is unaffected.
- R5: When `code_wr` is high at a clock edge, `wr_data` loads the blank code. That cycle's `wr_en` is ignored: neither the store nor the write pointer changes.
- R6: With `decoded` low, `scan_out` is the binary position 0 to 15. The position advances by one every TICK_DIV×SLOT_TICKS clocks (16 by default) and wraps from 15 to 0.
- R7: With `decoded` high, `scan_out` is 1 shifted left by the position (0001, 0010, 0100, 1000). Only positions 0 to 3 are visited. The position wraps to 0 from 3, or from any higher position it held when the mode changed.
- R8: Each position slot is SLOT_TICKS ticks of TICK_DIV clocks. `disp_blank` is high during the first and the last tick of every slot, so it is high for at least one tick on each side of every scan code change.
- R9: While `blank_all` is high, `disp_blank` is high.
- R10: With both `blank_a` and `blank_b` high, `{out_a, out_b}` as one 8-bit port equals the whole blank code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Character write strobe |
| code_wr | input | 1 | Blank-code load strobe; has priority over `wr_en` |
| wr_data | input | 8 | Character or blank-code data |
| decoded | input | 1 | 0 = binary scan code, 1 = one-hot scan over 4 lines |
| blank_a | input | 1 | Blank the upper nibble port |
| blank_b | input | 1 | Blank the lower nibble port |
| blank_all | input | 1 | Force the display-blank output high |
| scan_out | output | 4 | Scan code for the current digit |
| out_a | output | 4 | Upper nibble of the current character, or blank code |
| out_b | output | 4 | Lower nibble of the current character, or blank code |
| disp_blank | output | 1 | Display blank strobe |

## Verification
The bench targets four corner cases:
- **Pointer wrap on the 17th write.** A design that mishandles it leaves position 0 holding the old character, or writes past the store.
- **Same-cycle `code_wr` and `wr_en`.** A wrong priority either corrupts a character or advances the pointer, which shifts every later character one place.
- **Changing `decoded` while the position is above 3.** A design that compares only for equality with 3 runs on to 15 before it wraps, and shows dark digits for a long time.
- **Blank strobe edges.** The bench checks `disp_blank` one clock before and one clock after each scan code change. An off-by-one slot counter leaves the digit lit while the code switches, which causes ghosting.

// File: rtl/disp_refresh_pkg.sv
package disp_refresh_pkg;
   // Number of nibble ports a character is split into.
   localparam int unsigned NIB_PORTS = 2;

   // Scan line encoding selected by the decoded input.
   typedef enum logic {
      SCAN_BINARY = 1'b0,
      SCAN_ONEHOT = 1'b1
   } scan_mode_e;

   function automatic int unsigned min_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/scan_timer.sv
module scan_timer
   import disp_refresh_pkg::*;
#(
   parameter int unsigned TICK_DIV   = 4,
   parameter int unsigned SLOT_TICKS = 4,
   parameter int unsigned NUM_POS    = 16,
   parameter int unsigned DEC_POS    = 4,
   localparam int unsigned PW = min_w(NUM_POS)
) (
   input  logic          clk,
   input  logic          rst,
   input  scan_mode_e    mode,
   output logic [PW-1:0] pos_o,
   output logic          edge_blank_o
);
   localparam int unsigned CW = min_w(TICK_DIV);
   localparam int unsigned SW = min_w(SLOT_TICKS);

   logic [CW-1:0] pre_q;
   logic [SW-1:0] slot_q;
   logic [PW-1:0] pos_q;
   logic          tick;
   logic          slot_end;
   logic [PW-1:0] last_pos;

   assign tick     = (pre_q == CW'(TICK_DIV - 1));
   assign slot_end = tick && (slot_q == SW'(SLOT_TICKS - 1));
   assign last_pos = (mode == SCAN_ONEHOT) ? PW'(DEC_POS - 1) : PW'(NUM_POS - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         pre_q  <= '0;
         slot_q <= '0;
         pos_q  <= '0;
      end else begin
         pre_q <= tick ? '0 : pre_q + 1'b1;
         if (tick) begin
            slot_q <= slot_end ? '0 : slot_q + 1'b1;
         end
         if (slot_end) begin
            pos_q <= (pos_q >= last_pos) ? '0 : pos_q + 1'b1;
         end
      end
   end

   assign pos_o        = pos_q;
   assign edge_blank_o = (slot_q == '0) || (slot_q == SW'(SLOT_TICKS - 1));
endmodule

// File: rtl/char_store.sv
module char_store #(
   parameter int unsigned NUM_POS = 16,
   parameter int unsigned CHAR_W  = 8,
   localparam int unsigned PW = (NUM_POS > 1) ? $clog2(NUM_POS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [CHAR_W-1:0] wdata,
   input  logic [PW-1:0]     rd_pos,
   output logic [CHAR_W-1:0] rd_char,
   output logic [PW-1:0]     wr_ptr_o
);
   logic [CHAR_W-1:0] mem_q [NUM_POS];
   logic [PW-1:0]     ptr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr_q <= '0;
         for (int i = 0; i < NUM_POS; i++) begin
            mem_q[i] <= '0;
         end
      end else if (we) begin
         mem_q[ptr_q] <= wdata;
         ptr_q        <= (ptr_q == PW'(NUM_POS - 1)) ? '0 : ptr_q + 1'b1;
      end
   end

   assign rd_char  = mem_q[rd_pos];
   assign wr_ptr_o = ptr_q;
endmodule

// File: rtl/nibble_gate.sv
module nibble_gate #(
   parameter int unsigned NIB_W = 4
) (
   input  logic [NIB_W-1:0] data_i,
   input  logic [NIB_W-1:0] code_i,
   input  logic             blank_i,
   output logic [NIB_W-1:0] data_o
);
   assign data_o = blank_i ? code_i : data_i;
endmodule

// File: rtl/digit_refresh_ctrl.sv
module digit_refresh_ctrl
   import disp_refresh_pkg::*;
#(
   parameter int unsigned NUM_POS    = 16,
   parameter int unsigned CHAR_W     = 8,
   parameter int unsigned TICK_DIV   = 4,
   parameter int unsigned SLOT_TICKS = 4,
   localparam int unsigned SCAN_W = min_w(NUM_POS),
   localparam int unsigned NIB_W  = CHAR_W / NIB_PORTS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              code_wr,
   input  logic [CHAR_W-1:0] wr_data,
   input  logic              decoded,
   input  logic              blank_a,
   input  logic              blank_b,
   input  logic              blank_all,
   output logic [SCAN_W-1:0] scan_out,
   output logic [NIB_W-1:0]  out_a,
   output logic [NIB_W-1:0]  out_b,
   output logic              disp_blank
);
   localparam int unsigned DEC_POS = SCAN_W;
   localparam int unsigned DW      = min_w(DEC_POS);

   if (NUM_POS != (1 << SCAN_W)) begin : g_bad_pos
      $error("NUM_POS must be a power of two");
   end
   if (CHAR_W != NIB_W * NIB_PORTS) begin : g_bad_char
      $error("CHAR_W must split evenly into the nibble ports");
   end
   if (SLOT_TICKS < 2 || TICK_DIV < 1) begin : g_bad_slot
      $error("SLOT_TICKS must be at least 2 and TICK_DIV at least 1");
   end
   if (DEC_POS > NUM_POS) begin : g_bad_dec
      $error("one-hot scan needs no more lines than positions");
   end

   scan_mode_e        mode;
   logic [SCAN_W-1:0] pos;
   logic              edge_blank;
   logic [CHAR_W-1:0] cur_char;
   logic [SCAN_W-1:0] wr_ptr;
   logic [CHAR_W-1:0] bcode_q;
   logic [NIB_W-1:0]  nib_out [NIB_PORTS];
   logic [NIB_PORTS-1:0] nib_blank;

   assign mode = decoded ? SCAN_ONEHOT : SCAN_BINARY;

   always_ff @(posedge clk) begin
      if (rst) begin
         bcode_q <= '0;
      end else if (code_wr) begin
         bcode_q <= wr_data;
      end
   end

   scan_timer #(
      .TICK_DIV   (TICK_DIV),
      .SLOT_TICKS (SLOT_TICKS),
      .NUM_POS    (NUM_POS),
      .DEC_POS    (DEC_POS)
   ) i_timer (
      .clk          (clk),
      .rst          (rst),
      .mode         (mode),
      .pos_o        (pos),
      .edge_blank_o (edge_blank)
   );

   char_store #(
      .NUM_POS (NUM_POS),
      .CHAR_W  (CHAR_W)
   ) i_store (
      .clk      (clk),
      .rst      (rst),
      .we       (wr_en & ~code_wr),
      .wdata    (wr_data),
      .rd_pos   (pos),
      .rd_char  (cur_char),
      .wr_ptr_o (wr_ptr)
   );

   // Index 0 is the low nibble (port B), the top index is port A.
   assign nib_blank = {blank_a, blank_b};

   for (genvar g = 0; g < NIB_PORTS; g++) begin : g_nib
      nibble_gate #(.NIB_W(NIB_W)) i_gate (
         .data_i  (cur_char[g*NIB_W +: NIB_W]),
         .code_i  (bcode_q[g*NIB_W +: NIB_W]),
         .blank_i (nib_blank[g]),
         .data_o  (nib_out[g])
      );
   end

   assign out_a = nib_out[NIB_PORTS-1];
   assign out_b = nib_out[0];

   always_comb begin
      if (mode == SCAN_ONEHOT) begin
         scan_out = SCAN_W'(1) << pos[DW-1:0];
      end else begin
         scan_out = pos;
      end
   end

   assign disp_blank = edge_blank | blank_all;
endmodule

// File: rtl/digit_refresh_chk.sv
module digit_refresh_chk #(
   parameter int unsigned NUM_POS = 16,
   parameter int unsigned CHAR_W  = 8,
   parameter int unsigned SCAN_W  = 4,
   parameter int unsigned NIB_W   = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic              code_wr,
   input logic              decoded,
   input logic              blank_a,
   input logic              blank_all,
   input logic [SCAN_W-1:0] scan_out,
   input logic [NIB_W-1:0]  out_a,
   input logic              disp_blank,
   input logic [SCAN_W-1:0] wr_ptr,
   input logic [CHAR_W-1:0] bcode_q
);
   assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr_en) && !$past(code_wr) && $past(wr_ptr) == SCAN_W'(NUM_POS - 1))
      |-> (wr_ptr == '0));

   assert_nib_a_blank_R4: assert property (@(posedge clk) disable iff (rst)
      blank_a |-> (out_a == bcode_q[CHAR_W-1 -: NIB_W]));

   assert_code_no_ptr_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(code_wr)) |-> $stable(wr_ptr));

   assert_step_by_one_R6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !decoded && !$past(decoded) && scan_out != $past(scan_out))
      |-> (scan_out == $past(scan_out) + 1'b1));

   assert_onehot_scan_R7: assert property (@(posedge clk) disable iff (rst)
      decoded |-> ($countones(scan_out) == 1));

   assert_blank_at_step_R8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && decoded == $past(decoded) && scan_out != $past(scan_out))
      |-> (disp_blank && $past(disp_blank)));

   assert_force_blank_R9: assert property (@(posedge clk) disable iff (rst)
      blank_all |-> disp_blank);
endmodule

bind digit_refresh_ctrl digit_refresh_chk #(
   .NUM_POS (NUM_POS),
   .CHAR_W  (CHAR_W),
   .SCAN_W  (SCAN_W),
   .NIB_W   (NIB_W)
) i_chk (
   .clk        (clk),
   .rst        (rst),
   .wr_en      (wr_en),
   .code_wr    (code_wr),
   .decoded    (decoded),
   .blank_a    (blank_a),
   .blank_all  (blank_all),
   .scan_out   (scan_out),
   .out_a      (out_a),
   .disp_blank (disp_blank),
   .wr_ptr     (wr_ptr),
   .bcode_q    (bcode_q)
);

// File: tb/test_digit_refresh_ctrl.sv
module test_digit_refresh_ctrl;
   localparam int TICK = 4;
   localparam int SLOT = 4;
   localparam int L    = TICK * SLOT;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0, code_wr = 1'b0, decoded = 1'b0;
   logic       blank_a = 1'b0, blank_b = 1'b0, blank_all = 1'b0;
   logic [7:0] wr_data = '0;
   logic [3:0] scan_out, out_a, out_b;
   logic       disp_blank;

   int n_cmp = 0;
   int n_bad = 0;
   bit run_checks = 1'b0;

   // bench reference state
   logic [7:0] m_mem [16];
   logic [3:0] m_wp, m_pos;
   logic [7:0] m_bc;
   int         m_phase;
   bit         m_wrapped;

   always #2.5 clk = ~clk;

   digit_refresh_ctrl #(
      .NUM_POS(16), .CHAR_W(8), .TICK_DIV(TICK), .SLOT_TICKS(SLOT)
   ) i_digit_refresh_ctrl (
      .clk(clk), .rst(rst), .wr_en(wr_en), .code_wr(code_wr), .wr_data(wr_data),
      .decoded(decoded), .blank_a(blank_a), .blank_b(blank_b), .blank_all(blank_all),
      .scan_out(scan_out), .out_a(out_a), .out_b(out_b), .disp_blank(disp_blank)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] exp_scan(input logic [3:0] pos, input logic dec);
      return dec ? (4'd1 << pos[1:0]) : pos;
   endfunction

   function automatic logic exp_blank(input int phase, input logic force_on);
      return force_on || (phase < TICK) || (phase >= L - TICK);
   endfunction

   function automatic logic [3:0] exp_nib(input logic [7:0] ch, input logic [7:0] code,
                                          input logic blank, input bit upper);
      logic [7:0] src;
      src = blank ? code : ch;
      return upper ? src[7:4] : src[3:0];
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 16; i++) m_mem[i] <= '0;
         m_wp <= '0; m_pos <= '0; m_bc <= '0; m_phase <= 0; m_wrapped <= 1'b0;
      end else begin
         if (code_wr) m_bc <= wr_data;
         else if (wr_en) begin
            m_mem[m_wp] <= wr_data;
            if (m_wp == 4'd15) m_wrapped <= 1'b1;
            m_wp <= m_wp + 4'd1;
         end
         if (m_phase == L - 1) begin
            m_phase <= 0;
            m_pos <= (m_pos >= (decoded ? 4'd3 : 4'd15)) ? 4'd0 : m_pos + 4'd1;
         end else begin
            m_phase <= m_phase + 1;
         end
      end
   end

   always @(posedge clk) begin
      #1;
      if (run_checks && !rst) begin
         string ra, rb;
         chk(decoded ? "R7 one-hot scan" : "R6 binary scan", scan_out, exp_scan(m_pos, decoded));
         ra = (blank_a && blank_b) ? "R10 8-bit blank" : blank_a ? ((m_bc != 0) ? "R5/R4 port A" : "R4 port A")
              : (m_wrapped ? "R2/R3 port A" : "R3 port A");
         rb = (blank_a && blank_b) ? "R10 8-bit blank" : blank_b ? ((m_bc != 0) ? "R5/R4 port B" : "R4 port B")
              : (m_wrapped ? "R2/R3 port B" : "R3 port B");
         chk(ra, out_a, exp_nib(m_mem[m_pos], m_bc, blank_a, 1'b1));
         chk(rb, out_b, exp_nib(m_mem[m_pos], m_bc, blank_b, 1'b0));
         chk(blank_all ? "R9 forced blank" : "R8 edge blank", disp_blank, exp_blank(m_phase, blank_all));
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog (all requirements): actual 200000 cycles, expected earlier end");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      // R1: state straight out of reset
      rst = 1'b0;
      chk("R1 reset scan", scan_out, 0);
      chk("R1 reset port A", out_a, 0);
      chk("R1 reset port B", out_b, 0);
      chk("R1 reset blank strobe", disp_blank, 1);
      run_checks = 1'b1;

      // R2: 17 writes, last one lands on position 0
      for (int i = 0; i < 17; i++) begin
         wr_en = 1'b1; wr_data = 8'h10 + 8'(i);
         @(negedge clk);
      end
      wr_en = 1'b0;
      repeat (300) @(negedge clk);

      // R5: code load together with a write; the write must be ignored
      code_wr = 1'b1; wr_en = 1'b1; wr_data = 8'hA5;
      @(negedge clk);
      code_wr = 1'b0; wr_en = 1'b1; wr_data = 8'h3C;
      @(negedge clk);
      wr_en = 1'b0;
      blank_a = 1'b1; repeat (64) @(negedge clk);
      blank_b = 1'b1; repeat (64) @(negedge clk);
      blank_a = 1'b0; repeat (64) @(negedge clk);
      blank_b = 1'b0; blank_all = 1'b1; repeat (40) @(negedge clk);
      blank_all = 1'b0;

      // R7: switch to one-hot scan while position is high
      while (m_pos < 4'd8) @(negedge clk);
      decoded = 1'b1;
      repeat (200) @(negedge clk);
      decoded = 1'b0;
      repeat (50) @(negedge clk);

      // random mix
      for (int c = 0; c < 6000; c++) begin
         int r;
         r = $urandom_range(0, 999);
         wr_en   = (r < 100);
         code_wr = (r >= 100 && r < 120) || (r >= 90 && r < 100);
         wr_data = 8'($urandom);
         if ($urandom_range(0, 49) == 0) blank_a = ~blank_a;
         if ($urandom_range(0, 49) == 0) blank_b = ~blank_b;
         if ($urandom_range(0, 59) == 0) blank_all = ~blank_all;
         if ($urandom_range(0, 499) == 0) decoded = ~decoded;
         @(negedge clk);
      end
      wr_en = 1'b0; code_wr = 1'b0;
      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule